// File: doc/BRIEF.md
# Paired DIMM Error Resolver

This block sits after syndrome decoding in a memory error handling path. Its input is the description of one memory error on a chip-select. It reports which DIMM of that chip-select's pair holds the fault: the low one, the high one or both. When the answer cannot be given, it raises a configuration error or an insufficient-resolution error instead. For each error it takes four things:
- which of the two DIMM slots are populated;
- the ECC mode in force;
- the index of the lowest address bit that is known to be valid, together with address bit 3;
- whether the error was correctable, and the decoded symbol as a data or check flag plus the highest bit index the symbol covers.

In 64/8 mode each half of the data word carries its own check bits, so the address alone decides the DIMM, even for an uncorrectable error. In symbol (chipkill) mode a correctable error is placed by the position of its symbol. An uncorrectable error in that mode cannot be narrowed and names both DIMMs. The verdict is registered, and it is presented with a one-cycle strobe on the cycle after the request.

Top module: `dimm_pair_resolver`

## Requirements
- R1: When `dimm_present` is 2'b00 (bit 0 = low slot, bit 1 = high slot), the result has `err_cfg` = 1 and `dimm_sel` = 2'b00, whatever the other inputs are.
- R2: When exactly one bit of `dimm_present` is set, whichever slot it is, `dimm_sel` = 2'b01 (bit 0 = low DIMM, bit 1 = high DIMM), whatever the mode, address and symbol inputs are.
- R3: With both DIMMs present and `ecc_mode` = 0 (64/8 mode), the `correctable` flag has no effect, and an uncorrectable error still resolves to a single DIMM.
- R4: With both DIMMs present in 64/8 mode, a `low_valid_pos` above RES_MAX (default 3) gives `err_res` = 1 and `dimm_sel` = 2'b00. A value of RES_MAX or below resolves normally.
- R5: With both DIMMs present in 64/8 mode and sufficient resolution, `addr_b3` = 1 selects 2'b10 and `addr_b3` = 0 selects 2'b01.
- R6: With both DIMMs present, `ecc_mode` = 1 (symbol mode), `correctable` = 1 and `sym_is_data` = 1, a `sym_hi_bit` of DATA_HALF_MAX (default 63) or below selects 2'b01, and anything above it selects 2'b10.
- R7: With both DIMMs present, symbol mode, `correctable` = 1 and `sym_is_data` = 0 (check symbol), a `sym_hi_bit` of CHECK_HALF_MAX (default 7) or below selects 2'b01, and anything above it selects 2'b10.
- R8: With both DIMMs present, symbol mode and `correctable` = 0, `dimm_sel` = 2'b11, whatever the symbol inputs are.
- R9: `out_valid` is high exactly on the cycle after each cycle with `in_valid` high. While `out_valid` is low, `dimm_sel`, `err_cfg` and `err_res` are all 0.
- R10: While `out_valid` is high, exactly one of three things holds: `dimm_sel` is non-zero, `err_cfg` is set, or `err_res` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; the other inputs are sampled while it is high |
| dimm_present | input | 2 | Slot population: bit 0 = low DIMM, bit 1 = high DIMM |
| ecc_mode | input | 1 | 0 = 64/8 per-half ECC, 1 = symbol (chipkill) ECC |
| low_valid_pos | input | POS_W | Index of the lowest valid address bit |
| addr_b3 | input | 1 | Address bit 3 of the failing access |
| correctable | input | 1 | 1 when the error was corrected |
| sym_is_data | input | 1 | 1 = the symbol covers data bits, 0 = check bits |
| sym_hi_bit | input | HI_W | Highest bit index covered by the symbol |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| dimm_sel | output | 2 | DIMM verdict: 01 low, 10 high, 11 both, 00 on error or idle |
| err_cfg | output | 1 | No DIMM populated on the chip-select |
| err_res | output | 1 | The address resolution is too coarse to choose a DIMM |

## Verification
Every verdict is due exactly one clock after the cycle in which `in_valid` was sampled high. The driver stamps each expected item with the bench cycle number it must appear on. The monitor samples on the falling edge, pops the oldest item whenever `out_valid` is seen, and compares the stamp with the current cycle as well as the three result fields. A result that comes early, late, unexpected or never is therefore reported. On every cycle without a strobe, the monitor also checks that the result outputs are quiet.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

   typedef enum logic {
      ECC_HALVES = 1'b0,
      ECC_SYMBOL = 1'b1
   } ecc_mode_e;

   localparam int SEL_W = 2;
   typedef logic [SEL_W-1:0] dsel_t;

   localparam dsel_t SEL_NONE = 2'b00;
   localparam dsel_t SEL_LO   = 2'b01;
   localparam dsel_t SEL_HI   = 2'b10;
   localparam dsel_t SEL_BOTH = 2'b11;

   typedef struct packed {
      dsel_t sel;
      logic  cfg_err;
      logic  res_err;
   } verdict_t;

endpackage

// File: rtl/dpr_slot_count.sv
module dpr_slot_count #(
   parameter int NSLOT = 2
) (
   input  logic [NSLOT-1:0] present,
   output logic             none_fitted,
   output logic             one_fitted
);
   localparam int CNT_W = $clog2(NSLOT + 1);

   logic [CNT_W-1:0] partial [NSLOT+1];

   assign partial[0] = '0;

   generate
      for (genvar s = 0; s < NSLOT; s++) begin : g_acc
         assign partial[s+1] = partial[s] + CNT_W'(present[s]);
      end
   endgenerate

   assign none_fitted = (partial[NSLOT] == '0);
   assign one_fitted  = (partial[NSLOT] == CNT_W'(1));
endmodule

// File: rtl/dpr_halfword_pick.sv
module dpr_halfword_pick
   import dpr_pkg::*;
#(
   parameter int POS_W   = 6,
   parameter int RES_MAX = 3
) (
   input  logic [POS_W-1:0] low_valid_pos,
   input  logic             addr_b3,
   output dsel_t            sel,
   output logic             res_err
);
   localparam int POS_TOP = (1 << POS_W) - 1;

   logic fine_enough;

   generate
      if (RES_MAX >= POS_TOP) begin : g_always_fine
         assign fine_enough = 1'b1;
      end else begin : g_window
         localparam logic [POS_W-1:0] LIMIT = POS_W'(RES_MAX);
         assign fine_enough = (low_valid_pos <= LIMIT);
      end
   endgenerate

   always_comb begin
      if (!fine_enough) begin
         sel     = SEL_NONE;
         res_err = 1'b1;
      end else begin
         sel     = addr_b3 ? SEL_HI : SEL_LO;
         res_err = 1'b0;
      end
   end
endmodule

// File: rtl/dpr_symbol_pick.sv
module dpr_symbol_pick
   import dpr_pkg::*;
#(
   parameter int HI_W           = 8,
   parameter int DATA_HALF_MAX  = 63,
   parameter int CHECK_HALF_MAX = 7
) (
   input  logic            correctable,
   input  logic            sym_is_data,
   input  logic [HI_W-1:0] sym_hi_bit,
   output dsel_t           sel
);
   localparam logic [HI_W-1:0] DATA_LIM  = HI_W'(DATA_HALF_MAX);
   localparam logic [HI_W-1:0] CHECK_LIM = HI_W'(CHECK_HALF_MAX);

   logic in_low_data;
   logic in_low_check;
   logic in_low;

   assign in_low_data  = sym_is_data  && (sym_hi_bit <= DATA_LIM);
   assign in_low_check = !sym_is_data && (sym_hi_bit <= CHECK_LIM);
   assign in_low       = in_low_data || in_low_check;

   always_comb begin
      if (!correctable) begin
         sel = SEL_BOTH;
      end else if (in_low) begin
         sel = SEL_LO;
      end else begin
         sel = SEL_HI;
      end
   end
endmodule

// File: rtl/dpr_result_stage.sv
module dpr_result_stage
   import dpr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     take,
   input  verdict_t next_verdict,
   output logic     strobe,
   output verdict_t verdict
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe  <= 1'b0;
         verdict <= '0;
      end else begin
         strobe  <= take;
         verdict <= take ? next_verdict : '0;
      end
   end
endmodule

// File: rtl/dimm_pair_resolver.sv
module dimm_pair_resolver
   import dpr_pkg::*;
#(
   parameter int POS_W          = 6,
   parameter int HI_W           = 8,
   parameter int RES_MAX        = 3,
   parameter int DATA_HALF_MAX  = 63,
   parameter int CHECK_HALF_MAX = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        dimm_present,
   input  logic              ecc_mode,
   input  logic [POS_W-1:0]  low_valid_pos,
   input  logic              addr_b3,
   input  logic              correctable,
   input  logic              sym_is_data,
   input  logic [HI_W-1:0]   sym_hi_bit,
   output logic              out_valid,
   output logic [1:0]        dimm_sel,
   output logic              err_cfg,
   output logic              err_res
);
   localparam int NSLOT = 2;

   generate
      if (POS_W < 2 || POS_W > 16) begin : g_bad_pos_w
         $error("POS_W out of supported range");
      end
      if (HI_W < 1 || HI_W > 16) begin : g_bad_hi_w
         $error("HI_W out of supported range");
      end
      if (RES_MAX < 0) begin : g_bad_res
         $error("RES_MAX must not be negative");
      end
      if (DATA_HALF_MAX < 0 || DATA_HALF_MAX >= (1 << HI_W)) begin : g_bad_data
         $error("DATA_HALF_MAX does not fit in HI_W bits");
      end
      if (CHECK_HALF_MAX < 0 || CHECK_HALF_MAX >= (1 << HI_W)) begin : g_bad_check
         $error("CHECK_HALF_MAX does not fit in HI_W bits");
      end
   endgenerate

   logic      none_fitted;
   logic      one_fitted;
   dsel_t     half_sel;
   logic      half_res_err;
   dsel_t     sym_sel;
   verdict_t  next_verdict;
   verdict_t  held;
   ecc_mode_e mode;

   assign mode = ecc_mode_e'(ecc_mode);

   dpr_slot_count #(.NSLOT(NSLOT)) i_count (
      .present     (dimm_present),
      .none_fitted (none_fitted),
      .one_fitted  (one_fitted)
   );

   dpr_halfword_pick #(.POS_W(POS_W), .RES_MAX(RES_MAX)) i_half (
      .low_valid_pos (low_valid_pos),
      .addr_b3       (addr_b3),
      .sel           (half_sel),
      .res_err       (half_res_err)
   );

   dpr_symbol_pick #(
      .HI_W           (HI_W),
      .DATA_HALF_MAX  (DATA_HALF_MAX),
      .CHECK_HALF_MAX (CHECK_HALF_MAX)
   ) i_sym (
      .correctable (correctable),
      .sym_is_data (sym_is_data),
      .sym_hi_bit  (sym_hi_bit),
      .sel         (sym_sel)
   );

   always_comb begin
      next_verdict = '0;
      if (none_fitted) begin
         next_verdict.cfg_err = 1'b1;
      end else if (one_fitted) begin
         next_verdict.sel = SEL_LO;
      end else if (mode == ECC_HALVES) begin
         next_verdict.sel     = half_sel;
         next_verdict.res_err = half_res_err;
      end else begin
         next_verdict.sel = sym_sel;
      end
   end

   dpr_result_stage i_stage (
      .clk          (clk),
      .rst_n        (rst_n),
      .take         (in_valid),
      .next_verdict (next_verdict),
      .strobe       (out_valid),
      .verdict      (held)
   );

   assign dimm_sel = held.sel;
   assign err_cfg  = held.cfg_err;
   assign err_res  = held.res_err;
endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
   parameter int POS_W          = 6,
   parameter int HI_W           = 8,
   parameter int RES_MAX        = 3,
   parameter int DATA_HALF_MAX  = 63,
   parameter int CHECK_HALF_MAX = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [1:0]       dimm_present,
   input logic             ecc_mode,
   input logic [POS_W-1:0] low_valid_pos,
   input logic             addr_b3,
   input logic             correctable,
   input logic             sym_is_data,
   input logic [HI_W-1:0]  sym_hi_bit,
   input logic             out_valid,
   input logic [1:0]       dimm_sel,
   input logic             err_cfg,
   input logic             err_res
);
   localparam logic [POS_W-1:0] RLIM = POS_W'(RES_MAX);
   localparam logic [HI_W-1:0]  DLIM = HI_W'(DATA_HALF_MAX);
   localparam logic [HI_W-1:0]  CLIM = HI_W'(CHECK_HALF_MAX);

   p_none_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dimm_present == 2'b00) |=> (err_cfg && dimm_sel == 2'b00));

   p_single_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && $countones(dimm_present) == 1) |=> (dimm_sel == 2'b01));

   p_halves_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dimm_present == 2'b11 && !ecc_mode && low_valid_pos <= RLIM)
      |=> ($countones(dimm_sel) == 1));

   p_coarse_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dimm_present == 2'b11 && !ecc_mode && low_valid_pos > RLIM)
      |=> (err_res && dimm_sel == 2'b00));

   p_upper_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dimm_present == 2'b11 && !ecc_mode && low_valid_pos <= RLIM && addr_b3)
      |=> (dimm_sel == 2'b10));

   p_data_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dimm_present == 2'b11 && ecc_mode && correctable && sym_is_data
       && sym_hi_bit <= DLIM) |=> (dimm_sel == 2'b01));

   p_check_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dimm_present == 2'b11 && ecc_mode && correctable && !sym_is_data
       && sym_hi_bit > CLIM) |=> (dimm_sel == 2'b10));

   p_uncorr_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dimm_present == 2'b11 && ecc_mode && !correctable)
      |=> (dimm_sel == 2'b11));

   p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (dimm_sel == 2'b00 && !err_cfg && !err_res));

   p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones({|dimm_sel, err_cfg, err_res}) == 1));
endmodule

bind dimm_pair_resolver dpr_checker #(
   .POS_W          (POS_W),
   .HI_W           (HI_W),
   .RES_MAX        (RES_MAX),
   .DATA_HALF_MAX  (DATA_HALF_MAX),
   .CHECK_HALF_MAX (CHECK_HALF_MAX)
) i_dpr_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .dimm_present  (dimm_present),
   .ecc_mode      (ecc_mode),
   .low_valid_pos (low_valid_pos),
   .addr_b3       (addr_b3),
   .correctable   (correctable),
   .sym_is_data   (sym_is_data),
   .sym_hi_bit    (sym_hi_bit),
   .out_valid     (out_valid),
   .dimm_sel      (dimm_sel),
   .err_cfg       (err_cfg),
   .err_res       (err_res)
);

// File: tb/test_dimm_pair_resolver.sv
`timescale 1ns/1ps
module test_dimm_pair_resolver;
   localparam int POS_W = 6;
   localparam int HI_W  = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [1:0]       dimm_present = '0;
   logic             ecc_mode = 1'b0;
   logic [POS_W-1:0] low_valid_pos = '0;
   logic             addr_b3 = 1'b0;
   logic             correctable = 1'b0;
   logic             sym_is_data = 1'b0;
   logic [HI_W-1:0]  sym_hi_bit = '0;
   logic             out_valid;
   logic [1:0]       dimm_sel;
   logic             err_cfg;
   logic             err_res;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 1'b0;

   typedef struct {
      int         due;
      logic [1:0] sel;
      logic       cfg;
      logic       res;
      string      tag;
   } exp_t;

   exp_t sb[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dimm_pair_resolver i_dimm_pair_resolver (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (in_valid),
      .dimm_present  (dimm_present),
      .ecc_mode      (ecc_mode),
      .low_valid_pos (low_valid_pos),
      .addr_b3       (addr_b3),
      .correctable   (correctable),
      .sym_is_data   (sym_is_data),
      .sym_hi_bit    (sym_hi_bit),
      .out_valid     (out_valid),
      .dimm_sel      (dimm_sel),
      .err_cfg       (err_cfg),
      .err_res       (err_res)
   );

   task automatic send(input logic [1:0] pres, input logic mode, input int lp,
                       input logic b3, input logic corr, input logic dat, input int hi,
                       input logic [1:0] esel, input logic ecfg, input logic eres,
                       input string tag);
      exp_t e;
      @(negedge clk);
      in_valid      = 1'b1;
      dimm_present  = pres;
      ecc_mode      = mode;
      low_valid_pos = POS_W'(lp);
      addr_b3       = b3;
      correctable   = corr;
      sym_is_data   = dat;
      sym_hi_bit    = HI_W'(hi);
      e.due = cyc + 1;
      e.sel = esel;
      e.cfg = ecfg;
      e.res = eres;
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // Monitor: pops the scoreboard whenever a strobe appears
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (rst_n && !done) begin
            if (out_valid) begin
               checks++;
               if (sb.size() == 0) begin
                  failures++;
                  $display("FAIL R9 unexpected strobe: actual sel=%b cfg=%b res=%b expected no result",
                           dimm_sel, err_cfg, err_res);
               end else begin
                  e = sb.pop_front();
                  if (cyc != e.due || dimm_sel !== e.sel || err_cfg !== e.cfg || err_res !== e.res) begin
                     failures++;
                     $display("FAIL %s: actual cyc=%0d sel=%b cfg=%b res=%b expected cyc=%0d sel=%b cfg=%b res=%b",
                              e.tag, cyc, dimm_sel, err_cfg, err_res, e.due, e.sel, e.cfg, e.res);
                  end
               end
            end else begin
               checks++;
               if (dimm_sel !== 2'b00 || err_cfg !== 1'b0 || err_res !== 1'b0) begin
                  failures++;
                  $display("FAIL R9 idle outputs: actual sel=%b cfg=%b res=%b expected 00/0/0",
                           dimm_sel, err_cfg, err_res);
               end
               if (sb.size() != 0 && sb[0].due <= cyc) begin
                  failures++;
                  e = sb.pop_front();
                  $display("FAIL %s missing strobe: actual none at cyc=%0d expected at cyc=%0d",
                           e.tag, cyc, e.due);
               end
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog: actual hung run expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || dimm_sel !== 2'b00 || err_cfg !== 1'b0 || err_res !== 1'b0) begin
         failures++;
         $display("FAIL R9 reset state: actual v=%b sel=%b cfg=%b res=%b expected 0/00/0/0",
                  out_valid, dimm_sel, err_cfg, err_res);
      end
      rst_n = 1'b1;
      idle(2);

      // R1: nothing fitted
      send(2'b00, 1'b0, 0, 1'b1, 1'b1, 1'b1, 0, 2'b00, 1'b1, 1'b0, "R1 none fitted 64/8");
      send(2'b00, 1'b1, 40, 1'b0, 1'b0, 1'b0, 200, 2'b00, 1'b1, 1'b0, "R1 none fitted symbol");
      // R2: single DIMM in either slot
      send(2'b01, 1'b0, 10, 1'b1, 1'b1, 1'b1, 0, 2'b01, 1'b0, 1'b0, "R2 low slot coarse addr");
      send(2'b10, 1'b1, 0, 1'b0, 1'b0, 1'b0, 100, 2'b01, 1'b0, 1'b0, "R2 high slot uncorrectable");
      send(2'b10, 1'b0, 0, 1'b1, 1'b1, 1'b0, 0, 2'b01, 1'b0, 1'b0, "R2 high slot b3 set");
      idle(1);
      // R5: address bit 3 picks the half
      send(2'b11, 1'b0, 0, 1'b0, 1'b1, 1'b1, 0, 2'b01, 1'b0, 1'b0, "R5 b3 clear");
      send(2'b11, 1'b0, 0, 1'b1, 1'b1, 1'b1, 0, 2'b10, 1'b0, 1'b0, "R5 b3 set");
      // R4: resolution window boundary
      send(2'b11, 1'b0, 3, 1'b1, 1'b1, 1'b0, 0, 2'b10, 1'b0, 1'b0, "R4 lowest valid at limit");
      send(2'b11, 1'b0, 4, 1'b1, 1'b1, 1'b0, 0, 2'b00, 1'b0, 1'b1, "R4 lowest valid above limit");
      send(2'b11, 1'b0, 63, 1'b0, 1'b0, 1'b0, 0, 2'b00, 1'b0, 1'b1, "R4 lowest valid max");
      // R3: uncorrectable in 64/8 mode still one DIMM
      send(2'b11, 1'b0, 2, 1'b1, 1'b0, 1'b1, 200, 2'b10, 1'b0, 1'b0, "R3 uncorrectable upper");
      send(2'b11, 1'b0, 1, 1'b0, 1'b0, 1'b0, 5, 2'b01, 1'b0, 1'b0, "R3 uncorrectable lower");
      idle(2);
      // R6: data symbol placement
      send(2'b11, 1'b1, 20, 1'b1, 1'b1, 1'b1, 63, 2'b01, 1'b0, 1'b0, "R6 data hi at 63");
      send(2'b11, 1'b1, 20, 1'b0, 1'b1, 1'b1, 64, 2'b10, 1'b0, 1'b0, "R6 data hi at 64");
      send(2'b11, 1'b1, 0, 1'b1, 1'b1, 1'b1, 0, 2'b01, 1'b0, 1'b0, "R6 data hi at 0");
      send(2'b11, 1'b1, 0, 1'b0, 1'b1, 1'b1, 127, 2'b10, 1'b0, 1'b0, "R6 data hi at 127");
      // R7: check symbol placement
      send(2'b11, 1'b1, 9, 1'b1, 1'b1, 1'b0, 7, 2'b01, 1'b0, 1'b0, "R7 check hi at 7");
      send(2'b11, 1'b1, 9, 1'b0, 1'b1, 1'b0, 8, 2'b10, 1'b0, 1'b0, "R7 check hi at 8");
      send(2'b11, 1'b1, 0, 1'b1, 1'b1, 1'b0, 3, 2'b01, 1'b0, 1'b0, "R7 check hi at 3");
      idle(1);
      // R8: uncorrectable symbol error
      send(2'b11, 1'b1, 0, 1'b0, 1'b0, 1'b1, 3, 2'b11, 1'b0, 1'b0, "R8 uncorrectable data");
      send(2'b11, 1'b1, 50, 1'b1, 1'b0, 1'b0, 100, 2'b11, 1'b0, 1'b0, "R8 uncorrectable check");
      // R10: alternate outcome kinds back to back
      send(2'b00, 1'b1, 0, 1'b0, 1'b1, 1'b1, 0, 2'b00, 1'b1, 1'b0, "R10 cfg after select");
      send(2'b11, 1'b0, 5, 1'b0, 1'b1, 1'b1, 0, 2'b00, 1'b0, 1'b1, "R10 res after cfg");
      send(2'b11, 1'b1, 5, 1'b0, 1'b1, 1'b1, 10, 2'b01, 1'b0, 1'b0, "R10 select after res");
      idle(4);

      checks++;
      if (sb.size() != 0) begin
         failures++;
         $display("FAIL R9 results outstanding: actual %0d left expected 0", sb.size());
      end
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule